// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers the interrupt sources of a small 8-bit microcontroller core into a single interrupt request and a wake-up signal. It owns one 8-bit control register. That register holds a sticky flag and an enable bit for each of three core sources:

- an edge on an external pin, with a selectable polarity;
- a one-cycle timer overflow pulse;
- a change on a four-pin slice of an I/O port.

The register also holds a peripheral enable that gates the OR of the already-masked peripheral requests, and a global enable.

The request output is a level that the core samples to branch to its interrupt vector. The wake output tells a sleeping core that an enabled source is pending, whatever the global enable says. The pin and port inputs are asynchronous and pass through two synchronizer flops first. The port-change detector compares the synchronized pins against a latch that the core refreshes each time it reads the port.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the control register reads 8'h00, and irq and wake are 0.
- R2: A register write loads all eight bits, which read back on reg_rdata. The bit layout is: bit 7 global enable, bit 6 peripheral enable, bit 5 timer enable, bit 4 external enable, bit 3 port enable, bit 2 timer flag, bit 1 external flag, bit 0 port flag. A hardware event in the same cycle as a write sets its flag regardless of the written value.
- R3: A high tmr_ovf in one cycle sets bit 2 on the following clock edge.
- R4: No bit of the register falls except through a register write. Flags stay set over any number of idle cycles.
- R5: A change on ext_pin matching the polarity sets bit 1 on the third clock edge after the change, with rising selected when ext_rise_sel is 1 and falling when it is 0. An edge of the opposite polarity leaves bit 1 clear.
- R6: Bit 0 sets on every clock edge while the synchronized port pins differ from the read latch and port_rd is low. The latch resets to 0 and loads the synchronized pins on each cycle with port_rd high. A write of 0 therefore does not clear bit 0 until a port read has taken place.
- R7: A port change whose first synchronized cycle coincides with port_rd high is absorbed into the latch and never sets bit 0.
- R8: irq equals bit7 AND ((bit2 AND bit5) OR (bit1 AND bit4) OR (bit0 AND bit3) OR (bit6 AND any periph_req)).
- R9: wake equals sleep AND the same term without bit 7. It ignores the global enable and is 0 whenever sleep is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control register value |
| ext_rise_sel | input | 1 | 1 selects the rising edge, 0 the falling edge of ext_pin |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | PORTW | Asynchronous port pins watched for change |
| port_rd | input | 1 | Core read of the port; refreshes the change latch |
| tmr_ovf | input | 1 | One-cycle timer rollover pulse |
| periph_req | input | NPER | Already-masked peripheral requests |
| sleep | input | 1 | Core is in sleep |
| irq | output | 1 | Interrupt request level |
| wake | output | 1 | Wake-up request |

## Verification
Every cycle, the in-line properties check four things:
- the request and wake equations;
- that register bits fall only through writes;
- that a timer pulse lands in its flag one cycle later;
- that a port read blocks the port flag.

The synchronizer latency and the edge polarity choice can only be shown by the bench's timed pin sequences. So can the flag that refuses to clear while the port still differs, and the change lost during a read. These scenarios sample reg_rdata on the exact edge counts.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NPER  = 4,
  parameter int PORTW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ext_rise_sel,
  input  logic             ext_pin,
  input  logic [PORTW-1:0] port_pins,
  input  logic             port_rd,
  input  logic             tmr_ovf,
  input  logic [NPER-1:0]  periph_req,
  input  logic             sleep,
  output logic             irq,
  output logic             wake
);

  logic [7:0]       ctl;
  logic             ext_s1, ext_s2, ext_q;
  logic [PORTW-1:0] port_s1, port_s2, port_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1  <= 1'b0;
      ext_s2  <= 1'b0;
      ext_q   <= 1'b0;
      port_s1 <= '0;
      port_s2 <= '0;
    end else begin
      ext_s1  <= ext_pin;
      ext_s2  <= ext_s1;
      ext_q   <= ext_s2;
      port_s1 <= port_pins;
      port_s2 <= port_s1;
    end
  end

  wire ext_edge = ext_rise_sel ? (ext_s2 & ~ext_q) : (~ext_s2 & ext_q);
  wire port_chg = (port_s2 != port_lat) && !port_rd;
  wire [7:0] hw_set = {5'b0, tmr_ovf, ext_edge, port_chg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_lat <= '0;
      ctl      <= 8'h00;
    end else begin
      if (port_rd) port_lat <= port_s2;
      ctl <= (reg_wr ? reg_wdata : ctl) | hw_set;
    end
  end

  wire periph_any = |periph_req;
  wire pending = (ctl[2] & ctl[5]) | (ctl[1] & ctl[4]) | (ctl[0] & ctl[3]) |
                 (ctl[6] & periph_any);

  assign reg_rdata = ctl;
  assign irq       = ctl[7] & pending;
  assign wake      = sleep & pending;

  a_r8_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[7] |-> !irq);

  a_r8_irq_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && reg_rdata[6] && (periph_req != '0)) |-> irq);

  a_r9_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> !wake);

  a_r9_wake_ignores_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && reg_rdata[5] && reg_rdata[2]) |-> wake);

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> ((reg_rdata & 8'hF8) == ($past(reg_wdata) & 8'hF8)));

  a_r3_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> reg_rdata[2]);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((reg_rdata & $past(reg_rdata)) == $past(reg_rdata)));

  a_r7_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && !reg_wr && !reg_rdata[0]) |=> !reg_rdata[0]);

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/100ps
module irq_aggregator_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, ext_rise_sel = 1, ext_pin = 0, port_rd = 0, tmr_ovf = 0, sleep = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [3:0] port_pins = 0, periph_req = 0;
  logic irq, wake;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NPER(4), .PORTW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_rise_sel(ext_rise_sel), .ext_pin(ext_pin), .port_pins(port_pins), .port_rd(port_rd),
    .tmr_ovf(tmr_ovf), .periph_req(periph_req), .sleep(sleep), .irq(irq), .wake(wake));

  // {ctl, periph, sleep, exp_irq, exp_wake}
  localparam logic [11:0] VEC [10] = '{
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h24, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'hA4, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h84, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h92, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h89, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'hC0, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h80, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h40, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h8A, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d;
    cyc(1);
    reg_wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 reg", reg_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    cyc(1);
    chk("R1 wake", {7'b0, wake}, 8'h00);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][11:4]);
      periph_req = {3'b0, VEC[i][3]};
      sleep = VEC[i][2];
      #1;
      chk("R2 readback", reg_rdata, VEC[i][11:4]);
      chk("R8 irq", {7'b0, irq}, {7'b0, VEC[i][1]});
      chk("R9 wake", {7'b0, wake}, {7'b0, VEC[i][0]});
      cyc(1);
    end
    periph_req = 0; sleep = 0;
    wr(8'h00);

    // R3 timer pulse
    tmr_ovf = 1; cyc(1); tmr_ovf = 0;
    chk("R3 timer flag", reg_rdata, 8'h04);
    cyc(20);
    chk("R4 sticky", reg_rdata, 8'h04);
    wr(8'h00);
    chk("R4 write clears", reg_rdata, 8'h00);

    // R2 event beats same-cycle write
    reg_wr = 1; reg_wdata = 8'h20; tmr_ovf = 1; cyc(1); reg_wr = 0; tmr_ovf = 0;
    chk("R2 event wins", reg_rdata, 8'h24);
    wr(8'h00);

    // R5 rising
    ext_rise_sel = 1; ext_pin = 1;
    cyc(2);
    chk("R5 not yet", reg_rdata, 8'h00);
    cyc(1);
    chk("R5 rising sets", reg_rdata, 8'h02);
    wr(8'h00);
    ext_pin = 0; cyc(5);
    chk("R5 falling ignored", reg_rdata, 8'h00);
    ext_rise_sel = 0; ext_pin = 1; cyc(5);
    chk("R5 rising ignored", reg_rdata, 8'h00);
    ext_pin = 0; cyc(3);
    chk("R5 falling sets", reg_rdata, 8'h02);
    wr(8'h00);

    // R6 port change
    port_pins = 4'b0100;
    cyc(2);
    chk("R6 not yet", reg_rdata, 8'h00);
    cyc(1);
    chk("R6 change sets", reg_rdata, 8'h01);
    wr(8'h00);
    chk("R6 persists", reg_rdata, 8'h01);
    port_rd = 1; cyc(1); port_rd = 0;
    wr(8'h00);
    cyc(3);
    chk("R6 cleared after read", reg_rdata, 8'h00);

    // R7 change during read lost
    port_pins = 4'b1100;
    cyc(2);
    port_rd = 1; cyc(1); port_rd = 0;
    cyc(4);
    chk("R7 lost", reg_rdata, 8'h00);
    port_pins = 4'b0000; cyc(3);
    chk("R7 later change seen", reg_rdata, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule